// File: doc/BRIEF.md
# ACPI Embedded Controller Host Channel

This block is a byte-wide mailbox between a host processor and an embedded controller (EC), reached by the host through a small window of I/O ports. An address matches the window when it equals the configured base in every bit the configured mask leaves as "care". Inside the window, one address bit splits the data port from the command/status port. Host writes land in a single input byte. Host reads of the data port return an output byte, and host reads of the command/status port return a status byte. That byte carries output-full, input-full, an EC-owned busy bit, a flag recording whether the last host write went to the command port, and four general flags that the EC owns.

The EC works through a short register map. It can read the input byte, which also consumes it. It can load the output bytes, set or clear its own status bits, select the output mode, and acknowledge two interrupt flags by writing ones to them. One flag is raised when the host writes; the other is raised when the host drains the output. In single-byte mode only output byte 0 matters. In four-byte mode the EC stages all four bytes, and output-full goes up only when the last byte is written.

Top module: `hostport_mbox`

## Requirements
- R1: A host access hits when `((h_addr ^ cfg_base) & ~cfg_mask) == 0`. An access that misses changes no state and reads back 0x00.
- R2: Within the window, h_addr bit CMD_BIT (default 2) set selects the command/status port and clear selects the data port. The data byte index is `h_addr[1:0] & cfg_mask[1:0]`.
- R3: A host write that hits stores h_wdata as the input byte and sets input-full (status bit 1). It sets last-was-command (status bit 3) to 1 for the command port and 0 for the data port.
- R4: An EC read at EC address 4 returns the input byte and clears input-full. A host write in the same cycle wins, and input-full stays set.
- R5: Every host write that hits sets the input-full interrupt flag (irq_ibf, EC control bit 4). Writing 1 to control bit 4 at EC address 7 clears it.
- R6: The busy bit (status bit 2) and status bits 7:4 are owned by the EC. Writing to EC address 5 sets the bits given as ones, and writing to EC address 6 clears them. Status bits 0, 1 and 3 never change through these writes.
- R7: Four-byte mode is control bit 0 = 1. Writes to output bytes 0 to 2 (EC addresses 0 to 2) leave output-full alone, and a write to byte 3 (EC address 3) sets it. A host data read returns the byte picked by the R2 index.
- R8: Single-byte mode is control bit 0 = 0. An EC write of byte 0 sets output-full (status bit 0), writes to the other bytes do not, and a host data read returns byte 0.
- R9: When output-full is set, a host read drains the output, clears output-full and sets irq_obe (control bit 5). In single-byte mode any data read drains it; in four-byte mode only a read of byte 3 does. A read while output-full is clear raises nothing. Writing 1 to control bit 5 clears irq_obe, and an EC write that sets output-full wins over a drain in the same cycle.
- R10: A host read of the command/status port returns the status byte and changes no state.
- R11: After reset the status byte, both interrupt flags and the control register are zero, so the block starts in single-byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Window base address |
| cfg_mask | input | ADDR_W | Don't-care address bits |
| h_wr | input | 1 | Host I/O write strobe |
| h_rd | input | 1 | Host I/O read strobe |
| h_addr | input | ADDR_W | Host I/O address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, same cycle |
| ec_wr | input | 1 | EC register write strobe |
| ec_rd | input | 1 | EC register read strobe |
| ec_addr | input | clog2(OUT_BYTES+4) | EC register address |
| ec_wdata | input | 8 | EC write data |
| ec_rdata | output | 8 | EC read data, same cycle |
| irq_ibf | output | 1 | Input-full interrupt flag |
| irq_obe | output | 1 | Output-empty interrupt flag |

## Verification
The bench builds the block with its defaults (16-bit addresses, four output bytes, command select on bit 2). It then changes the decode inputs while running, from a two-port window with mask 0x04 to an eight-port window with mask 0x07. The narrow window covers decode misses on a neighbouring address and the single-byte handshake. The wide window makes the byte index reach all four output bytes, so partial four-byte fills, the drain on byte 3 and aliasing of the command port across upper addresses all become reachable. A same-cycle host write and EC consume exercises the input-full priority rule.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
  localparam int ST_OBF  = 0;
  localparam int ST_IBF  = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_CMD  = 3;
  // bits the EC may set or clear: busy and the four upper flags
  localparam logic [7:0] EC_OWNED = 8'hF4;

  // window match: all care bits of the address equal the base
  function automatic logic addr_hit(input logic [31:0] a, input logic [31:0] base,
                                    input logic [31:0] mask);
    return ((a ^ base) & ~mask) == 32'h0;
  endfunction

  // EC set/clear of its own status bits; clear applied after set
  function automatic logic [7:0] ec_bits_next(input logic [7:0] cur,
                                              input logic [7:0] set_m,
                                              input logic [7:0] clr_m);
    return ((cur | (set_m & EC_OWNED)) & ~(clr_m & EC_OWNED)) & EC_OWNED;
  endfunction

  // host-visible status composition
  function automatic logic [7:0] status_byte(input logic [7:0] ec_bits, input logic last_cmd,
                                             input logic ibf, input logic obf);
    logic [7:0] s;
    s = ec_bits & EC_OWNED;
    s[ST_CMD] = last_cmd;
    s[ST_IBF] = ibf;
    s[ST_OBF] = obf;
    return s;
  endfunction
endpackage

// File: rtl/hostport_decode.sv
module hostport_decode #(
  parameter int ADDR_W  = 16,
  parameter int SEL_W   = 2,
  parameter int CMD_BIT = 2
) (
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_mask,
  input  logic              h_wr,
  input  logic              h_rd,
  output logic              wr_data,
  output logic              wr_cmd,
  output logic              rd_data,
  output logic              rd_status,
  output logic [SEL_W-1:0]  byte_sel
);
  import hostport_pkg::*;

  logic hit;
  logic is_cmd;

  always_comb begin
    hit       = addr_hit(32'(h_addr), 32'(cfg_base), 32'(cfg_mask));
    is_cmd    = h_addr[CMD_BIT];
    wr_data   = hit && h_wr && !is_cmd;
    wr_cmd    = hit && h_wr &&  is_cmd;
    rd_data   = hit && h_rd && !is_cmd;
    rd_status = hit && h_rd &&  is_cmd;
    byte_sel  = h_addr[SEL_W-1:0] & cfg_mask[SEL_W-1:0];
  end
endmodule

// File: rtl/hostport_inbuf.sv
module hostport_inbuf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_cmd,
  input  logic [7:0] h_wdata,
  input  logic       ec_take,
  input  logic       sts_set_we,
  input  logic       sts_clr_we,
  input  logic [7:0] ec_wdata,
  output logic [7:0] in_byte,
  output logic       ibf,
  output logic       last_cmd,
  output logic [7:0] ec_bits
);
  import hostport_pkg::*;

  logic [7:0] set_m, clr_m;
  assign set_m = sts_set_we ? ec_wdata : 8'h00;
  assign clr_m = sts_clr_we ? ec_wdata : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_byte  <= 8'h00;
      ibf      <= 1'b0;
      last_cmd <= 1'b0;
      ec_bits  <= 8'h00;
    end else begin
      if (host_wr) begin
        in_byte  <= h_wdata;
        ibf      <= 1'b1;
        last_cmd <= host_cmd;
      end else if (ec_take) begin
        ibf <= 1'b0;
      end
      ec_bits <= ec_bits_next(ec_bits, set_m, clr_m);
    end
  end

  a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> ibf && (last_cmd == $past(host_cmd)) && (in_byte == $past(h_wdata)));
  a_r4_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ec_take && !host_wr |=> !ibf);
  a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    sts_set_we && !sts_clr_we |=> ((ec_bits & $past(ec_wdata) & EC_OWNED) == ($past(ec_wdata) & EC_OWNED)));
  a_r6_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    sts_clr_we |=> ((ec_bits & $past(ec_wdata)) == 8'h00));
endmodule

// File: rtl/hostport_outbuf.sv
module hostport_outbuf #(
  parameter int OUT_BYTES = 4,
  parameter int SEL_W     = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [OUT_BYTES-1:0]      byte_we,
  input  logic [7:0]                ec_wdata,
  input  logic                      quad,
  input  logic                      host_rd,
  input  logic [SEL_W-1:0]          byte_sel,
  output logic [OUT_BYTES-1:0][7:0] bytes,
  output logic [7:0]                host_byte,
  output logic                      obf,
  output logic                      drain_evt
);
  localparam int LAST = OUT_BYTES - 1;

  logic [SEL_W-1:0] rd_sel;
  logic             fill_evt;

  for (genvar i = 0; i < OUT_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bytes[i] <= 8'h00;
      else if (byte_we[i]) bytes[i] <= ec_wdata;
    end
  end

  always_comb begin
    rd_sel    = quad ? byte_sel : '0;
    host_byte = bytes[rd_sel];
    fill_evt  = quad ? byte_we[LAST] : byte_we[0];
    drain_evt = host_rd && obf && (!quad || rd_sel == SEL_W'(LAST));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         obf <= 1'b0;
    else if (fill_evt)  obf <= 1'b1;
    else if (drain_evt) obf <= 1'b0;
  end

  a_r8_single_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !quad && byte_we[0] |=> obf);
  a_r7_quad_partial: assert property (@(posedge clk) disable iff (!rst_n)
    quad && !obf && !byte_we[LAST] |=> !obf);
  a_r7_quad_last: assert property (@(posedge clk) disable iff (!rst_n)
    quad && byte_we[LAST] |=> obf);
  a_r9_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    drain_evt && !fill_evt |=> !obf);
endmodule

// File: rtl/hostport_mbox.sv
module hostport_mbox #(
  parameter int ADDR_W    = 16,
  parameter int OUT_BYTES = 4,
  parameter int CMD_BIT   = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              cfg_base,
  input  logic [ADDR_W-1:0]              cfg_mask,
  input  logic                           h_wr,
  input  logic                           h_rd,
  input  logic [ADDR_W-1:0]              h_addr,
  input  logic [7:0]                     h_wdata,
  output logic [7:0]                     h_rdata,
  input  logic                           ec_wr,
  input  logic                           ec_rd,
  input  logic [$clog2(OUT_BYTES+4)-1:0] ec_addr,
  input  logic [7:0]                     ec_wdata,
  output logic [7:0]                     ec_rdata,
  output logic                           irq_ibf,
  output logic                           irq_obe
);
  import hostport_pkg::*;

  localparam int SEL_W = $clog2(OUT_BYTES);
  localparam int EC_AW = $clog2(OUT_BYTES + 4);
  localparam logic [EC_AW-1:0] A_IN  = EC_AW'(OUT_BYTES);
  localparam logic [EC_AW-1:0] A_SET = EC_AW'(OUT_BYTES + 1);
  localparam logic [EC_AW-1:0] A_CLR = EC_AW'(OUT_BYTES + 2);
  localparam logic [EC_AW-1:0] A_CTL = EC_AW'(OUT_BYTES + 3);

  // named internal events
  logic wr_data, wr_cmd, rd_data, rd_status, host_wr_any;
  logic [SEL_W-1:0] byte_sel;
  logic ec_take, set_we, clr_we, ctl_we;
  logic [OUT_BYTES-1:0] byte_we;
  logic [OUT_BYTES-1:0][7:0] bytes;
  logic [7:0] host_byte, in_byte, ec_bits, status;
  logic ibf, last_cmd, obf, drain_evt, quad;

  hostport_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .CMD_BIT(CMD_BIT)) u_decode (
    .h_addr(h_addr), .cfg_base(cfg_base), .cfg_mask(cfg_mask), .h_wr(h_wr), .h_rd(h_rd),
    .wr_data(wr_data), .wr_cmd(wr_cmd), .rd_data(rd_data), .rd_status(rd_status),
    .byte_sel(byte_sel));

  assign host_wr_any = wr_data || wr_cmd;
  assign ec_take     = ec_rd && (ec_addr == A_IN);
  assign set_we      = ec_wr && (ec_addr == A_SET);
  assign clr_we      = ec_wr && (ec_addr == A_CLR);
  assign ctl_we      = ec_wr && (ec_addr == A_CTL);

  for (genvar i = 0; i < OUT_BYTES; i++) begin : g_we
    assign byte_we[i] = ec_wr && (ec_addr == EC_AW'(i));
  end

  hostport_inbuf u_inbuf (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr_any), .host_cmd(wr_cmd), .h_wdata(h_wdata),
    .ec_take(ec_take), .sts_set_we(set_we), .sts_clr_we(clr_we), .ec_wdata(ec_wdata),
    .in_byte(in_byte), .ibf(ibf), .last_cmd(last_cmd), .ec_bits(ec_bits));

  hostport_outbuf #(.OUT_BYTES(OUT_BYTES), .SEL_W(SEL_W)) u_outbuf (
    .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .ec_wdata(ec_wdata), .quad(quad),
    .host_rd(rd_data), .byte_sel(byte_sel), .bytes(bytes), .host_byte(host_byte),
    .obf(obf), .drain_evt(drain_evt));

  assign status = status_byte(ec_bits, last_cmd, ibf, obf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad    <= 1'b0;
      irq_ibf <= 1'b0;
      irq_obe <= 1'b0;
    end else begin
      if (ctl_we) quad <= ec_wdata[0];
      if (host_wr_any)              irq_ibf <= 1'b1;
      else if (ctl_we && ec_wdata[4]) irq_ibf <= 1'b0;
      if (drain_evt)                irq_obe <= 1'b1;
      else if (ctl_we && ec_wdata[5]) irq_obe <= 1'b0;
    end
  end

  always_comb begin
    if (rd_status)    h_rdata = status;
    else if (rd_data) h_rdata = host_byte;
    else              h_rdata = 8'h00;
  end

  always_comb begin
    ec_rdata = 8'h00;
    if (ec_addr < A_IN)                          ec_rdata = bytes[ec_addr[SEL_W-1:0]];
    else if (ec_addr == A_IN)                    ec_rdata = in_byte;
    else if (ec_addr == A_SET || ec_addr == A_CLR) ec_rdata = status;
    else if (ec_addr == A_CTL)                   ec_rdata = {2'b00, irq_obe, irq_ibf, 3'b000, quad};
  end

  a_r5_ibf_irq: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_any |=> irq_ibf);
  a_r9_obe_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && obf && !quad |=> irq_obe);
  a_r10_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !ec_wr && !ec_rd |=> $stable(status) && $stable(irq_ibf) && $stable(irq_obe));
  a_r1_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr || h_rd) && !host_wr_any && !rd_data && !rd_status && !ec_wr && !ec_rd
    |=> $stable(status) && $stable(in_byte) && $stable(irq_ibf) && $stable(irq_obe));
endmodule

// File: tb/hostport_mbox_bench.sv
module hostport_mbox_bench;
  localparam int ADDR_W = 16;
  localparam int EC_AW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] cfg_base = 16'h0062, cfg_mask = 16'h0004;
  logic h_wr = 0, h_rd = 0;
  logic [ADDR_W-1:0] h_addr = '0;
  logic [7:0] h_wdata = 0, h_rdata;
  logic ec_wr = 0, ec_rd = 0;
  logic [EC_AW-1:0] ec_addr = '0;
  logic [7:0] ec_wdata = 0, ec_rdata;
  logic irq_ibf, irq_obe;

  int checks = 0, errors = 0;
  bit done = 0;
  int          q_req[$];
  logic [7:0]  q_exp[$];

  always #10 clk = ~clk;

  hostport_mbox u_hostport_mbox (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .ec_wr(ec_wr), .ec_rd(ec_rd), .ec_addr(ec_addr), .ec_wdata(ec_wdata), .ec_rdata(ec_rdata),
    .irq_ibf(irq_ibf), .irq_obe(irq_obe));

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every read strobe, mid-cycle
  task automatic pop_cmp(input logic [7:0] act);
    if (q_exp.size() == 0) check(0, act, 8'hxx);
    else check(q_req.pop_front(), act, q_exp.pop_front());
  endtask

  always @(negedge clk) begin
    if (h_rd)  pop_cmp(h_rdata);
    if (ec_rd) pop_cmp(ec_rdata);
  end

  // driver tasks: each starts one time unit after an edge, lasts one cycle
  task automatic h_write(input logic [15:0] a, input logic [7:0] d);
    h_addr = a; h_wdata = d; h_wr = 1;
    @(posedge clk); #1 h_wr = 0;
  endtask
  task automatic h_read(input logic [15:0] a, input logic [7:0] exp, input int req);
    q_req.push_back(req); q_exp.push_back(exp);
    h_addr = a; h_rd = 1;
    @(posedge clk); #1 h_rd = 0;
  endtask
  task automatic e_write(input logic [2:0] a, input logic [7:0] d);
    ec_addr = a; ec_wdata = d; ec_wr = 1;
    @(posedge clk); #1 ec_wr = 0;
  endtask
  task automatic e_read(input logic [2:0] a, input logic [7:0] exp, input int req);
    q_req.push_back(req); q_exp.push_back(exp);
    ec_addr = a; ec_rd = 1;
    @(posedge clk); #1 ec_rd = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R0 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // R11 reset state
    e_read(3'd5, 8'h00, 11);
    e_read(3'd7, 8'h00, 11);
    h_read(16'h0066, 8'h00, 11);
    check(11, {7'b0, irq_ibf}, 8'h00);
    check(11, {7'b0, irq_obe}, 8'h00);
    // R3 command write, R10 status read twice
    h_write(16'h0066, 8'hA5);
    h_read(16'h0066, 8'h0A, 3);
    h_read(16'h0066, 8'h0A, 10);
    check(5, {7'b0, irq_ibf}, 8'h01);
    // R4 consume input
    e_read(3'd4, 8'hA5, 4);
    h_read(16'h0066, 8'h08, 4);
    // R5 acknowledge
    e_write(3'd7, 8'h10);
    check(5, {7'b0, irq_ibf}, 8'h00);
    // R3 data port write
    h_write(16'h0062, 8'h3C);
    h_read(16'h0066, 8'h02, 3);
    // R1 miss on neighbour address
    h_write(16'h0063, 8'h77);
    h_read(16'h0060, 8'h00, 1);
    e_read(3'd4, 8'h3C, 1);
    // R6 EC status bits
    e_write(3'd5, 8'hF7);
    h_read(16'h0066, 8'hF4, 6);
    e_write(3'd6, 8'h34);
    h_read(16'h0066, 8'hC0, 6);
    e_write(3'd5, 8'h0F);
    e_read(3'd5, 8'hC4, 6);
    e_write(3'd6, 8'hFF);
    h_read(16'h0066, 8'h00, 6);
    // R8 single-byte output
    e_write(3'd1, 8'h11);
    h_read(16'h0066, 8'h00, 8);
    e_write(3'd0, 8'h5A);
    h_read(16'h0066, 8'h01, 8);
    h_read(16'h0062, 8'h5A, 8);
    // R9 drain
    h_read(16'h0066, 8'h00, 9);
    check(9, {7'b0, irq_obe}, 8'h01);
    e_write(3'd7, 8'h20);
    check(9, {7'b0, irq_obe}, 8'h00);
    h_read(16'h0062, 8'h5A, 9);
    check(9, {7'b0, irq_obe}, 8'h00);
    // wide window, four-byte mode (R7, R2)
    cfg_base = 16'h0200; cfg_mask = 16'h0007;
    e_write(3'd7, 8'h01);
    e_write(3'd0, 8'h10);
    e_write(3'd1, 8'h21);
    e_write(3'd2, 8'h32);
    h_read(16'h0204, 8'h00, 7);
    e_write(3'd3, 8'h43);
    h_read(16'h0204, 8'h01, 7);
    h_read(16'h0201, 8'h21, 7);
    h_read(16'h0204, 8'h01, 9);
    check(9, {7'b0, irq_obe}, 8'h00);
    h_read(16'h0203, 8'h43, 7);
    h_read(16'h0205, 8'h00, 9);
    check(9, {7'b0, irq_obe}, 8'h01);
    h_read(16'h0200, 8'h10, 2);
    h_write(16'h0206, 8'h99);
    h_read(16'h0207, 8'h0A, 2);
    e_read(3'd7, 8'h31, 5);
    // R4 collision: host write beats EC consume
    q_req.push_back(4); q_exp.push_back(8'h99);
    ec_addr = 3'd4; ec_rd = 1; h_addr = 16'h0201; h_wdata = 8'h42; h_wr = 1;
    @(posedge clk); #1 ec_rd = 0; h_wr = 0;
    h_read(16'h0204, 8'h02, 4);
    e_read(3'd4, 8'h42, 4);
    check(0, 8'(q_exp.size()), 8'h00);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule